// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block collects a parameterized set of interrupt inputs (32 by default) and drives one registered request line toward a processor. Each input has its own configuration word holding a three-bit priority, a two-bit trigger selection and an enable bit. Level inputs are sampled directly in either polarity. Edge inputs capture an event into a pending flag that remains set until the event is acknowledged. Among the enabled, active inputs the highest priority number wins. When two winners share a priority, the lower input number wins, following a fixed chain.

Software works the block through a small register port. Reading the acknowledge location returns the number of the winning input, clears that input's captured edge, and pushes the winner's priority onto a stack of active levels. From then on only strictly higher priorities can raise the request line, which lets a higher-priority service interrupt a lower one. Writing the end-of-service location pops the stack and restores the previous level. A status location reports the current level and the depth of the stack.

Top module: `pnic_top`

## Requirements
- R1: After reset, irq_req is 0, every configuration word reads 0 (priority 0, trigger 00, disabled), and the status word reads 0.
- R2: The configuration word of input i (address i, i below 32) is read back as written, laid out as bits [2:0] priority (7 highest), bits [4:3] trigger (00 active-low level, 01 active-high level, 10 falling edge, 11 rising edge) and bit 5 enable.
- R3: An input whose enable bit is 0 never raises irq_req, whatever its input does.
- R4: A level input requests exactly while its input is at the active level. Nothing is held once the input returns to idle.
- R5: A rising-edge or falling-edge input captures only its selected edge. The captured request stays until that input is acknowledged or its configuration is rewritten. The opposite edge raises nothing.
- R6: Of several requesting inputs, the one with the greatest priority number is reported.
- R7: Among requesting inputs of equal priority, the lowest input number is reported.
- R8: A read of address 0x20 returns bit 7 = 1 and bits [4:0] = the winning input number when a request is allowed. Otherwise it returns 0 and changes no state.
- R9: After an acknowledge, irq_req is 0 in the following cycle. It is raised again only by a request whose priority is strictly above the top of the level stack; equal or lower priorities stay blocked.
- R10: A write to address 0x21 pops the level stack and restores the previous level. On an empty stack it has no effect.
- R11: A read of address 0x22 returns bits [2:0] = top level (0 when empty), bit 3 = stack not empty, bits [7:4] = stack depth.
- R12: irq_req is registered. It reflects inputs and state as sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Interrupt inputs, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (acknowledge read has side effects) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 6 | Write data (configuration word layout) |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_re |
| irq_req | output | 1 | Request toward the processor |

## Verification
The assertions assume that the inputs are already synchronous to clk. They also assume at most one register access per cycle, so an acknowledge read never falls in the same cycle as an end-of-service write. Under those assumptions the stack can neither overflow nor underflow, and each pushed level lies above the one beneath it. The stimulus changes inputs and strobes only on falling clock edges and issues one access at a time. It pairs every acknowledge with a single end-of-service write, plus one deliberate extra write on an empty stack.

// File: rtl/pnic_pkg.sv
package pnic_pkg;
   // trigger selection, values are the configuration-word encoding
   typedef enum logic [1:0] {
      TRIG_LVL_LO = 2'b00,
      TRIG_LVL_HI = 2'b01,
      TRIG_FALL   = 2'b10,
      TRIG_RISE   = 2'b11
   } trig_e;

   localparam int PNIC_TRIG_W = 2;

   function automatic logic trig_is_edge(input trig_e t);
      return t[1];
   endfunction
endpackage

// File: rtl/pnic_source.sv
module pnic_source
   import pnic_pkg::*;
#(
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_i,
   input  logic              cfg_we,
   input  logic [PRIO_W-1:0] wr_prio,
   input  trig_e             wr_trig,
   input  logic              wr_en,
   input  logic              ack_clr,
   output logic [PRIO_W-1:0] prio_o,
   output trig_e             trig_o,
   output logic              en_o,
   output logic              req_o
);
   logic prev_q;
   logic pend_q;
   logic edge_now;
   logic raw_req;

   always_comb begin
      case (trig_o)
         TRIG_RISE: edge_now = src_i & ~prev_q;
         TRIG_FALL: edge_now = ~src_i & prev_q;
         default:   edge_now = 1'b0;
      endcase
   end

   always_comb begin
      if (trig_is_edge(trig_o))
         raw_req = pend_q | edge_now;
      else if (trig_o == TRIG_LVL_HI)
         raw_req = src_i;
      else
         raw_req = ~src_i;
   end

   assign req_o = en_o & raw_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_o <= '0;
         trig_o <= TRIG_LVL_LO;
         en_o   <= 1'b0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (cfg_we) begin
            prio_o <= wr_prio;
            trig_o <= wr_trig;
            en_o   <= wr_en;
         end
         if (cfg_we || ack_clr)
            pend_q <= 1'b0;
         else if (edge_now)
            pend_q <= 1'b1;
      end
   end

   // R5: a captured edge survives until acknowledge or reconfiguration
   a_r5_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_is_edge(trig_o) && pend_q && !ack_clr && !cfg_we) |=> pend_q);
endmodule

// File: rtl/pnic_arbiter.sv
module pnic_arbiter #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   localparam int ID_W  = $clog2(NSRC)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSRC-1:0]              req_i,
   input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
   output logic                         found_o,
   output logic [ID_W-1:0]              id_o,
   output logic [PRIO_W-1:0]            prio_o
);
   // scan from the top index down; ">=" lets a lower index take a tie
   always_comb begin
      found_o = 1'b0;
      id_o    = '0;
      prio_o  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i] && (!found_o || prio_i[i] >= prio_o)) begin
            found_o = 1'b1;
            id_o    = ID_W'(i);
            prio_o  = prio_i[i];
         end
      end
   end

   // R6: the reported winner is itself requesting at the reported level
   a_r6_winner_requests: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (req_i[id_o] && prio_i[id_o] == prio_o));
   // R6: no quiet inputs produce a winner
   a_r6_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> !found_o);
endmodule

// File: rtl/pnic_stack.sv
module pnic_stack #(
   parameter int DEPTH  = 8,
   parameter int PRIO_W = 3,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [PRIO_W-1:0] push_val_i,
   output logic [PRIO_W-1:0] top_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              nonempty_o
);
   logic [DEPTH-1:0][PRIO_W-1:0] mem_q;
   logic [CNT_W-1:0]             top_idx;

   initial begin : p_param_chk
      a_stack_depth_min: assert (DEPTH >= 2) else $error("stack depth below 2");
   end

   assign nonempty_o = (cnt_o != '0);
   assign top_idx    = cnt_o - 1'b1;
   assign top_o      = nonempty_o ? mem_q[top_idx[PTR_W-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
         cnt_o <= '0;
      end else if (push_i && pop_i) begin
         mem_q[top_idx[PTR_W-1:0]] <= push_val_i;
      end else if (push_i) begin
         mem_q[cnt_o[PTR_W-1:0]] <= push_val_i;
         cnt_o <= cnt_o + 1'b1;
      end else if (pop_i) begin
         cnt_o <= cnt_o - 1'b1;
      end
   end

   // R10: the stack never grows past its depth nor pops when empty
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> (cnt_o < CNT_W'(DEPTH)));
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> nonempty_o);
endmodule

// File: rtl/pnic_top.sv
module pnic_top
   import pnic_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int PRIO_W      = 3,
   parameter int STACK_DEPTH = 2 ** PRIO_W,
   parameter int ADDR_W      = 6,
   parameter int ACK_ADDR    = 32,
   parameter int EOI_ADDR    = 33,
   parameter int STAT_ADDR   = 34,
   localparam int ID_W       = $clog2(NSRC),
   localparam int CNT_W      = $clog2(STACK_DEPTH + 1),
   localparam int CFG_W      = PRIO_W + PNIC_TRIG_W + 1,
   localparam int RD_W       = PRIO_W + 1 + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CFG_W-1:0]  reg_wdata,
   output logic [RD_W-1:0]   reg_rdata,
   output logic              irq_req
);
   initial begin : p_param_chk
      a_cfg_addr_fit: assert (ACK_ADDR >= NSRC && EOI_ADDR >= NSRC && STAT_ADDR >= NSRC)
         else $error("control addresses overlap source configuration");
      a_ctl_addr_range: assert (STAT_ADDR < 2 ** ADDR_W && ACK_ADDR < 2 ** ADDR_W && EOI_ADDR < 2 ** ADDR_W)
         else $error("control address outside address width");
      a_id_fits_addr: assert (ID_W <= ADDR_W) else $error("address too narrow");
      a_ack_word_fit: assert (ID_W + 1 <= RD_W) else $error("read word too narrow");
      a_levels_fit: assert (STACK_DEPTH >= 2 ** PRIO_W) else $error("stack shallower than levels");
   end

   logic [NSRC-1:0]              req;
   logic [NSRC-1:0][PRIO_W-1:0]  prio;
   trig_e                        trig [NSRC];
   logic [NSRC-1:0]              en;
   logic [NSRC-1:0]              ack_clr;
   logic                         found;
   logic [ID_W-1:0]              best_id;
   logic [PRIO_W-1:0]            best_prio;
   logic [PRIO_W-1:0]            top_lvl;
   logic [CNT_W-1:0]             depth;
   logic                         nonempty;
   logic                         allowed;
   logic                         ack_take;
   logic                         eoi;
   logic [RD_W-1:0]              rd_next;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      pnic_source #(.PRIO_W(PRIO_W)) src_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (src_in[gi]),
         .cfg_we  (reg_we && reg_addr == ADDR_W'(gi)),
         .wr_prio (reg_wdata[PRIO_W-1:0]),
         .wr_trig (trig_e'(reg_wdata[PRIO_W +: PNIC_TRIG_W])),
         .wr_en   (reg_wdata[CFG_W-1]),
         .ack_clr (ack_clr[gi]),
         .prio_o  (prio[gi]),
         .trig_o  (trig[gi]),
         .en_o    (en[gi]),
         .req_o   (req[gi])
      );
      assign ack_clr[gi] = ack_take && (best_id == ID_W'(gi));
   end

   pnic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .prio_i  (prio),
      .found_o (found),
      .id_o    (best_id),
      .prio_o  (best_prio)
   );

   assign allowed  = found && (!nonempty || best_prio > top_lvl);
   assign ack_take = reg_re && reg_addr == ADDR_W'(ACK_ADDR) && allowed;
   assign eoi      = reg_we && reg_addr == ADDR_W'(EOI_ADDR) && nonempty;

   pnic_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) stk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (ack_take),
      .pop_i      (eoi),
      .push_val_i (best_prio),
      .top_o      (top_lvl),
      .cnt_o      (depth),
      .nonempty_o (nonempty)
   );

   always_comb begin
      rd_next = '0;
      if (int'(reg_addr) < NSRC) begin
         rd_next[CFG_W-1:0] = {en[reg_addr[ID_W-1:0]], trig[reg_addr[ID_W-1:0]],
                               prio[reg_addr[ID_W-1:0]]};
      end else if (reg_addr == ADDR_W'(ACK_ADDR)) begin
         if (allowed) begin
            rd_next[RD_W-1]   = 1'b1;
            rd_next[ID_W-1:0] = best_id;
         end
      end else if (reg_addr == ADDR_W'(STAT_ADDR)) begin
         rd_next[PRIO_W-1:0]      = top_lvl;
         rd_next[PRIO_W]          = nonempty;
         rd_next[PRIO_W+1 +: CNT_W] = depth;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         irq_req   <= 1'b0;
      end else begin
         if (reg_re) reg_rdata <= rd_next;
         irq_req <= allowed && !ack_take;
      end
   end

   // R9: each pushed level lies strictly above the level it covers
   a_r9_push_above: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && nonempty && !eoi) |-> (best_prio > top_lvl));
   // R9: the cycle after an acknowledge the request line is low
   a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> !irq_req);
   // R3: nothing requests when every input is disabled
   a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !irq_req);
endmodule

// File: tb/pnic_top_tb_top.sv
module pnic_top_tb_top;
   localparam logic [5:0] A_ACK  = 6'h20;
   localparam logic [5:0] A_EOI  = 6'h21;
   localparam logic [5:0] A_STAT = 6'h22;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [5:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_req;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always #10 clk = ~clk;

   pnic_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
   );

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      check(irq_req === e, tag, {7'd0, irq_req}, {7'd0, e});
   endtask

   task automatic wr(input logic [5:0] a, input logic [5:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // driver: issue a read and queue the value the requirements predict
   task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
      reg_re = 1'b1; reg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   // monitor: compare each returned read word against the queue head
   always @(posedge clk) rd_seen <= reg_re;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underrun", reg_rdata, 8'h00);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(reg_rdata === e, t, reg_rdata, e);
         end
      end
   end

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin : watchdog
      #(20ns * 100000);
      check(1'b0, "watchdog expired", 8'h00, 8'h00);
      finish_run();
   end

   initial begin : stim
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(A_STAT, 8'h00, "R1 status after reset");
      rd(6'd5, 8'h00, "R1 config after reset");
      rd(A_ACK, 8'h00, "R8 ack with no request");

      // R2 configuration readback
      wr(6'd3, 6'h2A);
      rd(6'd3, 8'h2A, "R2 readback source 3");

      // R3 disabled source
      wr(6'd4, 6'h0D);
      src_in[4] = 1'b1;
      tick(); tick();
      chk_irq(1'b0, "R3 disabled input silent");
      rd(6'd4, 8'h0D, "R2 readback source 4");

      // R4 / R12 active-high level
      src_in[3] = 1'b1;
      chk_irq(1'b0, "R12 no change before edge");
      tick();
      chk_irq(1'b1, "R4 high level requests");
      src_in[3] = 1'b0;
      tick();
      chk_irq(1'b0, "R4 high level not held");

      // R4 active-low level
      src_in[6] = 1'b1;
      wr(6'd6, 6'h21);
      tick();
      chk_irq(1'b0, "R4 low level idle high");
      src_in[6] = 1'b0;
      tick();
      chk_irq(1'b1, "R4 low level requests");
      src_in[6] = 1'b1;
      tick();
      chk_irq(1'b0, "R4 low level released");

      // R5 rising edge capture
      wr(6'd8, 6'h3B);
      src_in[8] = 1'b1;
      tick();
      src_in[8] = 1'b0;
      tick();
      chk_irq(1'b1, "R5 rising edge captured");
      tick();
      chk_irq(1'b1, "R5 capture held");
      rd(A_ACK, 8'h88, "R8 ack returns source 8");
      chk_irq(1'b0, "R9 irq low after ack");
      rd(A_STAT, 8'h1B, "R11 status one level 3");
      wr(A_EOI, 6'h00);
      rd(A_STAT, 8'h00, "R10 status after pop");
      chk_irq(1'b0, "R5 capture cleared by ack");

      // R5 falling edge capture
      wr(6'd9, 6'h33);
      src_in[9] = 1'b1;
      tick(); tick();
      chk_irq(1'b0, "R5 opposite edge ignored");
      src_in[9] = 1'b0;
      tick(); tick();
      chk_irq(1'b1, "R5 falling edge captured");
      rd(A_ACK, 8'h89, "R8 ack returns source 9");
      wr(A_EOI, 6'h00);

      // R6, R7, R9, R10 nesting
      wr(6'd10, 6'h2E);
      wr(6'd11, 6'h2E);
      wr(6'd12, 6'h2F);
      src_in[3] = 1'b1; src_in[10] = 1'b1; src_in[11] = 1'b1;
      tick();
      chk_irq(1'b1, "R6 request present");
      rd(A_ACK, 8'h8A, "R7 tie goes to lower number");
      rd(A_STAT, 8'h1E, "R11 status level 6 depth 1");
      chk_irq(1'b0, "R9 equal priority blocked");
      src_in[12] = 1'b1;
      tick();
      chk_irq(1'b1, "R9 higher priority preempts");
      rd(A_ACK, 8'h8C, "R9 nested ack source 12");
      rd(A_STAT, 8'h2F, "R11 status level 7 depth 2");
      chk_irq(1'b0, "R9 blocked at top level");
      src_in[12] = 1'b0;
      wr(A_EOI, 6'h00);
      rd(A_STAT, 8'h1E, "R10 previous level restored");
      tick();
      chk_irq(1'b0, "R9 level 6 still blocked");
      src_in[10] = 1'b0;
      wr(A_EOI, 6'h00);
      rd(A_STAT, 8'h00, "R10 stack emptied");
      tick();
      chk_irq(1'b1, "R9 request returns after pop");
      rd(A_ACK, 8'h8B, "R6 priority 6 beats priority 2");
      wr(A_EOI, 6'h00);
      src_in[11] = 1'b0;
      tick();
      rd(A_ACK, 8'h83, "R6 remaining lower source");
      wr(A_EOI, 6'h00);
      wr(A_EOI, 6'h00);
      rd(A_STAT, 8'h00, "R10 pop on empty ignored");
      src_in[3] = 1'b0;
      tick(); tick();
      chk_irq(1'b0, "R4 all idle");
      tick();
      finish_run();
   end
endmodule